// File: doc/BRIEF.md
# ATA Register PIO Access Sequencer

This block carries out one 16-bit programmed-I/O transfer to or from a register of an ATA/IDE device. The host raises `start_i` for one cycle with a direction flag, a 4-bit register number and, for writes, a data word. The sequencer then steps through a fixed run of states. It drives the device register address and the two chip selects, pulses the active-low read or write strobe, and handles the 16-bit bidirectional data bus. It ends by raising `done_o` for one cycle.

A read selects the register, waits one idle setup state and holds the read strobe for `STB_LEN` states. It captures the bus only in the final strobe state and then presents the word to the host. A write selects the register, captures the host word and turns on the bus drivers. It holds the write strobe for `STB_LEN` states with the drivers on, and ends with a recovery state in which the drivers are off. Both directions take six cycles with the default strobe length. The asynchronous reset input is released to the logic through a two-stage synchronizer.

Top module: `ata_pio_seq`

## Requirements
- R1: While the internal reset is active, and whenever no access is in progress, both chip selects and both strobes are high (inactive), the bus drivers are off and `done_o` is low.
- R2: `start_i` is accepted only while idle. A start pulse that arrives during an access has no effect: it does not start another access and does not produce an extra strobe or `done_o`.
- R3: A read has three phases in order. The first cycle after the accepting edge is the address state. The second is a setup state with no strobe. From the third cycle the read strobe is low for exactly `STB_LEN` (default 3) consecutive cycles.
- R4: The bus value is captured into `rdata_o` only at the edge that ends the last read-strobe cycle, and values present during earlier strobe cycles are discarded. `rdata_o` keeps that word until the next read completes, including across write accesses.
- R5: A write selects the register in the first cycle. At the end of that cycle it captures `wdata_i`, and it drives the captured word onto the bus from the second cycle. From the third cycle the write strobe is low for exactly `STB_LEN` cycles, with the drivers on and the word on the bus throughout.
- R6: A write ends with one recovery state after the strobe, in which no strobe is active and the bus drivers are off.
- R7: `reg_addr_i[2:0]` drives `ide_da_o`. `reg_addr_i[3]`=0 pulls `ide_cs0_n_o` low and `reg_addr_i[3]`=1 pulls `ide_cs1_n_o` low; never both are low. Address and chip selects are captured at the accepting edge and stay unchanged from the first state to the last state of the access.
- R8: `done_o` is a one-cycle pulse in cycle `STB_LEN`+3 after the accepting edge (cycle 6 by default) for both reads and writes. In a read this is the cycle in which `rdata_o` first shows the new word, and in a write it is the recovery cycle.
- R9: The read and write strobes are never low together, and the bus drivers are never on while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin an access |
| wr_i | input | 1 | 1 = write, 0 = read, sampled with `start_i` |
| reg_addr_i | input | 4 | Register number: bit 3 chooses the chip select, bits 2:0 the register address |
| wdata_i | input | 16 | Write word, captured at the end of the first state |
| rdata_o | output | 16 | Last word read from the device |
| done_o | output | 1 | One-cycle completion pulse |
| ide_da_o | output | 3 | Device register address lines |
| ide_cs0_n_o | output | 1 | Active-low chip select for the command block |
| ide_cs1_n_o | output | 1 | Active-low chip select for the control block |
| ide_dior_n_o | output | 1 | Active-low read strobe |
| ide_diow_n_o | output | 1 | Active-low write strobe |
| ide_dd_io | inout | 16 | Bidirectional device data bus |

## Verification
The bound checker watches every cycle for properties that hold on the pins and on the driver enable. It checks that the two strobes never overlap and that no driver is on during a read strobe. It checks that each strobe run lasts exactly `STB_LEN` cycles, that the chip selects are idle whenever no access is in progress, and that address and selects stay still during an access. It also checks that the write recovery cycle has the drivers off and `done_o` high, and that `done_o` lasts one cycle. Other behaviours need the bench's scenarios. These are which bus sample is captured (the device model drives inverted data in the early strobe cycles), whether the written word reaches the right register, whether a stray start pulse is ignored, whether `rdata_o` holds across writes, and the exact latency from start to done.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [3:0] {
    ST_IDLE    = 4'd0,
    ST_RD_ADDR = 4'd1,
    ST_RD_GAP  = 4'd2,
    ST_RD_STB  = 4'd3,
    ST_RD_DONE = 4'd4,
    ST_WR_ADDR = 4'd5,
    ST_WR_LOAD = 4'd6,
    ST_WR_STB  = 4'd7,
    ST_WR_REC  = 4'd8
  } pio_state_e;

  // Internal active-high controls derived from the current state.
  typedef struct packed {
    logic addr_en;
    logic rd_stb;
    logic wr_stb;
    logic drv_en;
    logic wd_load;
    logic done;
  } pio_ctl_t;

  function automatic pio_ctl_t decode_ctl(input pio_state_e st);
    pio_ctl_t c;
    c = '0;
    unique case (st)
      ST_RD_ADDR: c.addr_en = 1'b1;
      ST_RD_GAP:  c.addr_en = 1'b1;
      ST_RD_STB: begin
        c.addr_en = 1'b1;
        c.rd_stb  = 1'b1;
      end
      ST_RD_DONE: begin
        c.addr_en = 1'b1;
        c.done    = 1'b1;
      end
      ST_WR_ADDR: begin
        c.addr_en = 1'b1;
        c.wd_load = 1'b1;
      end
      ST_WR_LOAD: begin
        c.addr_en = 1'b1;
        c.drv_en  = 1'b1;
      end
      ST_WR_STB: begin
        c.addr_en = 1'b1;
        c.wr_stb  = 1'b1;
        c.drv_en  = 1'b1;
      end
      ST_WR_REC: begin
        c.addr_en = 1'b1;
        c.done    = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ata_pio_rst_sync.sv
module ata_pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ata_pio_fsm.sv
module ata_pio_fsm
  import ata_pio_pkg::*;
#(
  parameter int unsigned STB_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       wr_i,
  output pio_state_e state_o,
  output logic       stb_last_o,
  output logic       accept_o
);

  localparam int unsigned CNT_W = (STB_LEN > 1) ? $clog2(STB_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_LEN - 1);

  pio_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic in_stb;
  logic stb_last;

  assign in_stb   = (state_q == ST_RD_STB) || (state_q == ST_WR_STB);
  assign stb_last = in_stb && (cnt_q == CNT_LAST);
  assign accept_o = (state_q == ST_IDLE) && start_i;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = wr_i ? ST_WR_ADDR : ST_RD_ADDR;
      end
      ST_RD_ADDR: state_d = ST_RD_GAP;
      ST_RD_GAP:  state_d = ST_RD_STB;
      ST_RD_STB:  if (stb_last) state_d = ST_RD_DONE;
      ST_RD_DONE: state_d = ST_IDLE;
      ST_WR_ADDR: state_d = ST_WR_LOAD;
      ST_WR_LOAD: state_d = ST_WR_STB;
      ST_WR_STB:  if (stb_last) state_d = ST_WR_REC;
      ST_WR_REC:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // Strobe-length counter next value and enable
  always_comb begin
    cnt_en = in_stb || (cnt_q != '0);
    cnt_d  = (in_stb && !stb_last) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state_o    = state_q;
  assign stb_last_o = stb_last;

endmodule

// File: rtl/ata_pio_addr.sv
module ata_pio_addr #(
  parameter int unsigned DA_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [DA_W:0]   addr_i,
  input  logic            addr_en_i,
  output logic [DA_W-1:0] da_o,
  output logic            cs0_n_o,
  output logic            cs1_n_o
);

  logic [DA_W:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load_i) begin
      addr_q <= addr_i;
    end
  end

  assign da_o    = addr_q[DA_W-1:0];
  assign cs0_n_o = ~(addr_en_i & ~addr_q[DA_W]);
  assign cs1_n_o = ~(addr_en_i &  addr_q[DA_W]);

endmodule

// File: rtl/ata_pio_data.sv
module ata_pio_data #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_load_i,
  input  logic [DATA_W-1:0] bus_i,
  input  logic              drv_en_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] wd_q;
  logic [DATA_W-1:0] rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= '0;
    end else if (wd_load_i) begin
      wd_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_load_i) begin
      rd_q <= bus_i;
    end
  end

  assign bus_o   = wd_q;
  assign oe_o    = drv_en_i;
  assign rdata_o = rd_q;

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DA_W    = 3,
  parameter int unsigned STB_LEN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [DA_W:0]     reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [DA_W-1:0]   ide_da_o,
  output logic              ide_cs0_n_o,
  output logic              ide_cs1_n_o,
  output logic              ide_dior_n_o,
  output logic              ide_diow_n_o,
  inout  wire  [DATA_W-1:0] ide_dd_io
);

  logic              rst_sync_n;
  pio_state_e        state;
  pio_ctl_t          ctl;
  logic              stb_last;
  logic              accept;
  logic [DATA_W-1:0] dd_out;
  logic              dd_oe;

  ata_pio_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ata_pio_fsm #(.STB_LEN(STB_LEN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .wr_i       (wr_i),
    .state_o    (state),
    .stb_last_o (stb_last),
    .accept_o   (accept)
  );

  assign ctl = decode_ctl(state);

  ata_pio_addr #(.DA_W(DA_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (accept),
    .addr_i    (reg_addr_i),
    .addr_en_i (ctl.addr_en),
    .da_o      (ide_da_o),
    .cs0_n_o   (ide_cs0_n_o),
    .cs1_n_o   (ide_cs1_n_o)
  );

  ata_pio_data #(.DATA_W(DATA_W)) u_data (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wd_load_i (ctl.wd_load),
    .wdata_i   (wdata_i),
    .rd_load_i (ctl.rd_stb & stb_last),
    .bus_i     (ide_dd_io),
    .drv_en_i  (ctl.drv_en),
    .bus_o     (dd_out),
    .oe_o      (dd_oe),
    .rdata_o   (rdata_o)
  );

  // Strobes are active-high inside and active-low at the pins.
  assign ide_dior_n_o = ~ctl.rd_stb;
  assign ide_diow_n_o = ~ctl.wr_stb;
  assign done_o       = ctl.done;
  assign ide_dd_io    = dd_oe ? dd_out : {DATA_W{1'bz}};

endmodule

// File: rtl/ata_pio_seq_chk.sv
module ata_pio_seq_chk #(
  parameter int unsigned DA_W    = 3,
  parameter int unsigned STB_LEN = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dior_n,
  input logic            diow_n,
  input logic            cs0_n,
  input logic            cs1_n,
  input logic [DA_W-1:0] da,
  input logic            done,
  input logic            dd_oe
);

  logic [15:0] rd_run;
  logic [15:0] wr_run;
  logic        sel;

  assign sel = ~cs0_n | ~cs1_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
    end else begin
      rd_run <= dior_n ? 16'd0 : rd_run + 16'd1;
      wr_run <= diow_n ? 16'd0 : wr_run + 16'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs0_n && cs1_n) |-> (dior_n && diow_n && !dd_oe && !done));

  assert_rd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dior_n) |-> ($past(sel, 1) && $past(sel, 2) && $past(dior_n, 2)));

  assert_rd_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dior_n) |-> (rd_run == 16'(STB_LEN)));

  assert_wr_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diow_n) |-> (wr_run == 16'(STB_LEN)));

  assert_wr_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |-> dd_oe);

  assert_recovery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(diow_n) |-> (!dd_oe && done && dior_n));

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel)) |-> ($stable(da) && $stable(cs0_n) && $stable(cs1_n)));

  assert_one_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!cs0_n && !cs1_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  assert_no_drive_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |-> !dd_oe);

endmodule

bind ata_pio_seq ata_pio_seq_chk #(.DA_W(DA_W), .STB_LEN(STB_LEN)) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .dior_n (ide_dior_n_o),
  .diow_n (ide_diow_n_o),
  .cs0_n  (ide_cs0_n_o),
  .cs1_n  (ide_cs1_n_o),
  .da     (ide_da_o),
  .done   (done_o),
  .dd_oe  (dd_oe)
);

// File: tb/ata_pio_seq_tb_top.sv
`timescale 1ns/1ps
module ata_pio_seq_tb_top;

  localparam int DATA_W  = 16;
  localparam int DA_W    = 3;
  localparam int STB_LEN = 3;
  localparam int LAT     = STB_LEN + 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              wr = 1'b0;
  logic [DA_W:0]     addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  wire  [DATA_W-1:0] rdata;
  wire               done;
  wire  [DA_W-1:0]   da;
  wire               cs0_n, cs1_n, dior_n, diow_n;
  wire  [DATA_W-1:0] dd;

  always #10 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  ata_pio_seq #(.DATA_W(DATA_W), .DA_W(DA_W), .STB_LEN(STB_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .wr_i(wr), .reg_addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .ide_da_o(da),
    .ide_cs0_n_o(cs0_n), .ide_cs1_n_o(cs1_n), .ide_dior_n_o(dior_n),
    .ide_diow_n_o(diow_n), .ide_dd_io(dd)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Device model: register file; inverted data early in the read strobe.
  logic [DATA_W-1:0] dev_mem [16];
  logic [DATA_W-1:0] shadow  [16];
  logic [1:0] rd_cnt = '0;
  wire  [3:0] dev_idx = {~cs1_n, da};
  wire        dev_sel = cs0_n ^ cs1_n;

  always @(posedge clk) rd_cnt <= dior_n ? 2'd0 : ((rd_cnt == 2'd3) ? 2'd3 : rd_cnt + 2'd1);

  assign dd = (!dior_n && dev_sel)
            ? ((rd_cnt == 2'(STB_LEN - 1)) ? dev_mem[dev_idx] : ~dev_mem[dev_idx])
            : {DATA_W{1'bz}};

  always @(posedge clk) if (!diow_n && dev_sel) dev_mem[dev_idx] <= dd;

  initial begin
    for (int i = 0; i < 16; i++) begin
      dev_mem[i] = 16'((i + 1) * 16'h1357) ^ 16'hA0A0;
      shadow[i]  = 16'((i + 1) * 16'h1357) ^ 16'hA0A0;
    end
  end

  // Scoreboard
  typedef struct {
    bit                wr;
    logic [DA_W:0]     addr;
    logic [DATA_W-1:0] data;
    int unsigned       t0;
  } item_t;
  item_t q[$];

  int ndone   = 0;
  int rd_runs = 0;
  int wr_runs = 0;
  int rlen    = 0;
  int wlen    = 0;
  bit prev_done = 1'b0;

  task automatic chk_addr(input item_t it, input string req);
    chk(da == it.addr[DA_W-1:0], req, "da during strobe", 32'(da), 32'(it.addr[DA_W-1:0]));
    chk({cs1_n, cs0_n} == (it.addr[DA_W] ? 2'b01 : 2'b10), req, "chip selects {cs1_n,cs0_n}",
        32'({cs1_n, cs0_n}), it.addr[DA_W] ? 32'h1 : 32'h2);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) chk(1'b0, "R8", "done longer than one cycle", 32'd2, 32'd1);
      prev_done = done;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2", "done with no accepted request", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(cyc - it.t0 == LAT, "R8", "start-to-done latency", cyc - it.t0, LAT);
          if (it.wr) begin
            chk(dev_mem[it.addr] == it.data, "R5", "device register after write",
                32'(dev_mem[it.addr]), 32'(it.data));
            chk(diow_n && dior_n, "R6", "strobes in recovery", 32'({dior_n, diow_n}), 32'h3);
          end else begin
            chk(rdata == it.data, "R4", "read data at done", 32'(rdata), 32'(it.data));
          end
        end
        ndone++;
      end
      // read strobe run
      if (!dior_n) begin
        rlen++;
        if (q.size() == 0) begin
          chk(1'b0, "R2", "read strobe with no request", 32'd1, 32'd0);
        end else begin
          if (rlen == 1) chk(cyc - q[0].t0 == 3, "R3", "cycle of first read strobe",
                             cyc - q[0].t0, 32'd3);
          chk_addr(q[0], "R7");
        end
      end else if (rlen > 0) begin
        chk(rlen == STB_LEN, "R3", "read strobe length", rlen, STB_LEN);
        rlen = 0;
        rd_runs++;
      end
      // write strobe run
      if (!diow_n) begin
        wlen++;
        if (q.size() == 0) begin
          chk(1'b0, "R2", "write strobe with no request", 32'd1, 32'd0);
        end else begin
          if (wlen == 1) chk(cyc - q[0].t0 == 3, "R5", "cycle of first write strobe",
                             cyc - q[0].t0, 32'd3);
          chk(dd == q[0].data, "R5", "bus during write strobe", 32'(dd), 32'(q[0].data));
          chk_addr(q[0], "R7");
        end
      end else if (wlen > 0) begin
        chk(wlen == STB_LEN, "R5", "write strobe length", wlen, STB_LEN);
        wlen = 0;
        wr_runs++;
      end
    end
  end

  task automatic issue(input bit w, input logic [DA_W:0] a, input logic [DATA_W-1:0] d);
    item_t it;
    @(negedge clk);
    wr = w; addr = a; wdata = d; start = 1'b1;
    it.wr = w; it.addr = a; it.t0 = cyc;
    it.data = w ? d : shadow[a];
    if (w) shadow[a] = d;
    q.push_back(it);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (ndone < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [DA_W:0] a, input logic [DATA_W-1:0] d);
    int target;
    target = ndone + 1;
    issue(w, a, d);
    wait_done(target);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired: actual=%0d cycles expected=completion", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    int runs_before, done_before, target;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs0_n && cs1_n, "R1", "selects in reset", 32'({cs1_n, cs0_n}), 32'h3);
    chk(dior_n && diow_n, "R1", "strobes in reset", 32'({dior_n, diow_n}), 32'h3);
    chk(!done, "R1", "done in reset", 32'(done), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs0_n && cs1_n && dior_n && diow_n && !done, "R1", "idle after reset",
        32'({cs1_n, cs0_n, dior_n, diow_n, done}), 32'h1E);

    // R5 R7: writes to both register blocks, varied patterns
    access(1'b1, 4'h0, 16'h0000);
    access(1'b1, 4'h7, 16'hFFFF);
    access(1'b1, 4'h8, 16'hAAAA);
    access(1'b1, 4'hE, 16'h5555);
    access(1'b1, 4'h3, 16'hC3A5);
    // R3 R4: reads back, plus untouched registers
    access(1'b0, 4'h0, 16'h0);
    access(1'b0, 4'h7, 16'h0);
    access(1'b0, 4'h8, 16'h0);
    access(1'b0, 4'hE, 16'h0);
    access(1'b0, 4'h3, 16'h0);
    access(1'b0, 4'h5, 16'h0);
    access(1'b0, 4'hB, 16'h0);

    // R4: read data held across a write
    held = rdata;
    access(1'b1, 4'h1, 16'h9E37);
    repeat (2) @(negedge clk);
    chk(rdata == held, "R4", "rdata held across write", 32'(rdata), 32'(held));

    // R2: stray start during a read is ignored; address change mid-access too (R7)
    runs_before = wr_runs;
    done_before = ndone;
    target = ndone + 1;
    issue(1'b0, 4'h9, 16'h0);
    @(negedge clk);
    wr = 1'b1; addr = 4'h2; wdata = 16'h1111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(target);
    repeat (10) @(negedge clk);
    chk(ndone == done_before + 1, "R2", "done count after stray start", ndone, done_before + 1);
    chk(wr_runs == runs_before, "R2", "write strobes after stray start", wr_runs, runs_before);
    access(1'b0, 4'h2, 16'h0);

    // R6: back-to-back write then read to same register
    access(1'b1, 4'hF, 16'h0F0F);
    access(1'b0, 4'hF, 16'h0);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R8", "outstanding requests at end", q.size(), 32'd0);
    summary();
    $finish;
  end

endmodule